// File: doc/BRIEF.md
# Two-wire Serial Memory Slave Front End

This block is the slave-side protocol engine of a two-wire serial memory. It receives the raw clock and data lines, cleans them with synchronizers and a glitch filter, and recognizes start and stop conditions from the filtered levels. Bytes are shifted in MSB first on rising clock edges. Outgoing bits, including the acknowledge, change only after falling clock edges, and the data line is driven open-drain: the block only ever pulls it low.

The first byte after a start selects the device. Its upper nibble is a fixed tag, its next two bits are compared with the chip-select straps, the next bit extends the word address to 17 bits, and the lowest bit selects read or write. On a write, two address bytes and any number of data bytes follow, and each one is handed to downstream logic with a one-cycle strobe. On a read, the block takes bytes from downstream logic and sends them for as long as the master acknowledges. The memory array, the address counter and the programming timer live outside the block. A busy input makes the block ignore its own address, which is how the master polls for the end of a write cycle.

Top module: `twi_mem_slave`

## Requirements
- R1: After reset, `sda_oe_o` is 0, `word_addr_o` is 0 and no strobe is active.
- R2: A device byte (MSB first) is accepted when bits 7:4 equal 1010 and bits 3:2 equal `sel_strap_i[1:0]`. Bit 1 is the page bit and bit 0 selects read when 1. On acceptance the block pulses `sel_stb_o`, updates `rw_o` and pulls SDA low during the ninth clock.
- R3: A device byte with a wrong tag or wrong select bits gets no acknowledge, and all bytes that follow are ignored until the next start.
- R4: While `busy_i` is high at the eighth rising clock edge of the device byte, the block neither acknowledges nor pulses `sel_stb_o`.
- R5: On a write, the second byte pulses `ahi_stb_o`, the third pulses `alo_stb_o`, and every later byte pulses `wd_stb_o`, each with the byte on `byte_o`. Every byte is acknowledged. `word_addr_o` is {page bit, high byte, low byte}.
- R6: On a read, the block loads `rd_data_i` and pulses `rd_req_o` on the falling edge that starts each byte, then sends the byte MSB first. It continues after a master acknowledge and stops after a master no-acknowledge.
- R7: The block changes its SDA drive only after a falling SCL edge, a start or a stop, so the line stays stable while SCL is high.
- R8: A start in any state, including in the middle of a byte, aborts the transfer and restarts device-byte reception.
- R9: A stop in any state returns the block to idle with SDA released, and pulses `stop_stb_o`.
- R10: The sequence start, nine clocks with SDA high, start, stop leaves the block idle and ready to be addressed, even if it was interrupted in the middle of a transfer.
- R11: A pulse on SCL or SDA that lasts fewer than `GLITCH_CYC` system clocks is filtered out. It produces no edge, no start and no stop.
- R12: The byte strobes and `rd_req_o` last one cycle each and are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw serial clock line |
| sda_i | input | 1 | Raw serial data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain) |
| sel_strap_i | input | 2 | Chip-select straps compared with device byte bits 3:2 |
| busy_i | input | 1 | Write cycle in progress; do not acknowledge |
| rd_data_i | input | 8 | Next byte to send on a read |
| sel_stb_o | output | 1 | Device byte accepted |
| rw_o | output | 1 | Direction of the accepted access, 1 = read |
| ahi_stb_o | output | 1 | High address byte received |
| alo_stb_o | output | 1 | Low address byte received |
| wd_stb_o | output | 1 | Write data byte received |
| byte_o | output | 8 | Byte that goes with the current strobe |
| word_addr_o | output | 17 | Assembled word address {page, high, low} |
| rd_req_o | output | 1 | `rd_data_i` taken for transmission |
| stop_stb_o | output | 1 | Stop condition seen |

## Verification
The bench writes with the page bit set, so that bit 16 of the assembled address is checked, and reads three bytes from a counter so that dropped or repeated loads show up as wrong values. The address is also sent with a wrong tag, with wrong select bits and while busy; each of these separates rejection for a different reason from acceptance. Interrupted transfers (a start after four bits, and a recovery sequence in the middle of an address byte) show whether the receiver resynchronizes. Single-clock pulses on SCL in the middle of a write and on SDA on an idle bus show whether the filter hides them: if one got through, it would shift an extra bit or register a false stop.

// File: rtl/twi_pkg.sv
package twi_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2 * BYTE_W + 1;
    localparam logic [3:0] DEV_TAG = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK
    } st_e;

    typedef enum logic [1:0] {
        PH_DEV,
        PH_AHI,
        PH_ALO,
        PH_DAT
    } ph_e;

    typedef struct packed {
        st_e               st;
        ph_e               ph;
        logic [BYTE_W-1:0] sh;
        logic [3:0]        bits;
        logic              oe;
        logic              ack_on;
        logic              mack;
        logic              page;
        logic              rw;
        logic [BYTE_W-1:0] ahi;
        logic [BYTE_W-1:0] alo;
        logic [BYTE_W-1:0] byte_out;
        logic              sel_stb;
        logic              ahi_stb;
        logic              alo_stb;
        logic              wd_stb;
        logic              rd_req;
        logic              stop_stb;
    } regs_t;
endpackage

// File: rtl/twi_glitch_filter.sv
module twi_glitch_filter #(
    parameter int GLITCH_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(GLITCH_CYC + 1);

    logic [1:0]    sync_d, sync_q;
    logic [2:0]    hist_d, hist_q;
    logic [CW-1:0] cnt_d, cnt_q;
    logic          out_d, out_q;
    logic          maj;

    assign maj = (hist_q[0] & hist_q[1]) | (hist_q[1] & hist_q[2]) | (hist_q[0] & hist_q[2]);

    always_comb begin
        sync_d = {sync_q[0], din};
        hist_d = {hist_q[1:0], sync_q[1]};
        cnt_d  = '0;
        out_d  = out_q;
        if (maj != out_q) begin
            if (cnt_q == CW'(GLITCH_CYC - 1)) begin
                out_d = maj;
            end else begin
                cnt_d = cnt_q + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            hist_q <= '1;
            cnt_q  <= '0;
            out_q  <= 1'b1;
        end else begin
            sync_q <= sync_d;
            hist_q <= hist_d;
            cnt_q  <= cnt_d;
            out_q  <= out_d;
        end
    end

    assign dout = out_q;

    AST_FILT_NEEDS_MAJORITY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_q) |-> $past(maj != out_q)); // R11
endmodule

// File: rtl/twi_bus_cond.sv
module twi_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic scl_rise,
    output logic scl_fall,
    output logic start,
    output logic stop
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    assign scl_rise = !scl_q && scl;
    assign scl_fall = scl_q && !scl;
    assign start    = scl_q && scl && sda_q && !sda;
    assign stop     = scl_q && scl && !sda_q && sda;

    AST_COND_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({scl_rise, scl_fall, start, stop})); // R7
endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave
    import twi_pkg::*;
#(
    parameter int GLITCH_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [1:0]        sel_strap_i,
    input  logic              busy_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic              sel_stb_o,
    output logic              rw_o,
    output logic              ahi_stb_o,
    output logic              alo_stb_o,
    output logic              wd_stb_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic [ADDR_W-1:0] word_addr_o,
    output logic              rd_req_o,
    output logic              stop_stb_o
);
    localparam int NLINE = 2;
    localparam logic [3:0] LAST_BIT = 4'(BYTE_W - 1);

    logic [NLINE-1:0] raw_w, flt_w;
    logic scl_f, sda_f;
    logic scl_rise, scl_fall, start, stop;
    regs_t d, q;
    logic [BYTE_W-1:0] nb;

    assign raw_w = {scl_i, sda_i};

    for (genvar gi = 0; gi < NLINE; gi++) begin : g_line
        twi_glitch_filter #(.GLITCH_CYC(GLITCH_CYC)) u_flt (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_w[gi]),
            .dout (flt_w[gi])
        );
    end

    assign scl_f = flt_w[1];
    assign sda_f = flt_w[0];

    twi_bus_cond u_cond (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl     (scl_f),
        .sda     (sda_f),
        .scl_rise(scl_rise),
        .scl_fall(scl_fall),
        .start   (start),
        .stop    (stop)
    );

    assign nb = {q.sh[BYTE_W-2:0], sda_f};

    always_comb begin
        d          = q;
        d.sel_stb  = 1'b0;
        d.ahi_stb  = 1'b0;
        d.alo_stb  = 1'b0;
        d.wd_stb   = 1'b0;
        d.rd_req   = 1'b0;
        d.stop_stb = 1'b0;
        if (stop) begin
            d.st       = ST_IDLE;
            d.oe       = 1'b0;
            d.ack_on   = 1'b0;
            d.stop_stb = 1'b1;
        end else if (start) begin
            d.st     = ST_RX;
            d.ph     = PH_DEV;
            d.bits   = '0;
            d.oe     = 1'b0;
            d.ack_on = 1'b0;
        end else begin
            unique case (q.st)
                ST_RX: if (scl_rise) begin
                    d.sh   = nb;
                    d.bits = q.bits + 4'd1;
                    if (q.bits == LAST_BIT) begin
                        d.st       = ST_ACK;
                        d.byte_out = nb;
                        unique case (q.ph)
                            PH_DEV: begin
                                if (nb[7:4] == DEV_TAG && nb[3:2] == sel_strap_i && !busy_i) begin
                                    d.page    = nb[1];
                                    d.rw      = nb[0];
                                    d.sel_stb = 1'b1;
                                end else begin
                                    d.st = ST_IDLE;
                                end
                            end
                            PH_AHI: begin
                                d.ahi     = nb;
                                d.ahi_stb = 1'b1;
                            end
                            PH_ALO: begin
                                d.alo     = nb;
                                d.alo_stb = 1'b1;
                            end
                            default: d.wd_stb = 1'b1;
                        endcase
                    end
                end
                ST_ACK: if (scl_fall) begin
                    if (!q.ack_on) begin
                        d.ack_on = 1'b1;
                        d.oe     = 1'b1;
                    end else begin
                        d.ack_on = 1'b0;
                        d.bits   = '0;
                        if (q.ph == PH_DEV && q.rw) begin
                            d.st     = ST_TX;
                            d.sh     = rd_data_i;
                            d.rd_req = 1'b1;
                            d.oe     = !rd_data_i[BYTE_W-1];
                        end else begin
                            d.st = ST_RX;
                            d.oe = 1'b0;
                            unique case (q.ph)
                                PH_DEV:  d.ph = PH_AHI;
                                PH_AHI:  d.ph = PH_ALO;
                                default: d.ph = PH_DAT;
                            endcase
                        end
                    end
                end
                ST_TX: if (scl_fall) begin
                    if (q.bits == LAST_BIT) begin
                        d.st   = ST_MACK;
                        d.oe   = 1'b0;
                        d.mack = 1'b0;
                    end else begin
                        d.sh   = {q.sh[BYTE_W-2:0], 1'b0};
                        d.bits = q.bits + 4'd1;
                        d.oe   = !q.sh[BYTE_W-2];
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        if (sda_f) d.st = ST_IDLE;
                        else       d.mack = 1'b1;
                    end else if (scl_fall && q.mack) begin
                        d.st     = ST_TX;
                        d.bits   = '0;
                        d.sh     = rd_data_i;
                        d.rd_req = 1'b1;
                        d.oe     = !rd_data_i[BYTE_W-1];
                    end
                end
                default: d.oe = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
            q.ph <= PH_DEV;
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o    = q.oe;
    assign sel_stb_o   = q.sel_stb;
    assign rw_o        = q.rw;
    assign ahi_stb_o   = q.ahi_stb;
    assign alo_stb_o   = q.alo_stb;
    assign wd_stb_o    = q.wd_stb;
    assign byte_o      = q.byte_out;
    assign word_addr_o = {q.page, q.ahi, q.alo};
    assign rd_req_o    = q.rd_req;
    assign stop_stb_o  = q.stop_stb;

    AST_DRIVE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> $past(scl_fall || start || stop)); // R7
    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (q.st == ST_IDLE && !sda_oe_o)); // R9
    AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (q.st == ST_RX && q.ph == PH_DEV && q.bits == 4'd0)); // R8
    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_stb_o, ahi_stb_o, alo_stb_o, wd_stb_o, rd_req_o})); // R12
    AST_BUSY_NO_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        sel_stb_o |-> !$past(busy_i)); // R4
endmodule

// File: tb/sim_twi_mem_slave.sv
`timescale 1ns/1ps
module sim_twi_mem_slave;
    localparam int Q = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic m_low = 1'b0;
    logic glitch_low = 1'b0;
    logic [1:0] strap = 2'b10;
    logic busy = 1'b0;
    logic [7:0] rd_data;
    logic sda_oe, sel_stb, rw, ahi_stb, alo_stb, wd_stb, rd_req, stop_stb;
    logic [7:0] byte_w;
    logic [16:0] waddr;
    wire sda_line = !(m_low | glitch_low | sda_oe);

    int n_chk = 0, n_bad = 0;
    int sel_n = 0, ahi_n = 0, alo_n = 0, wd_n = 0, rd_n = 0, stop_n = 0;
    int unstable = 0;
    logic [7:0] wd_buf [0:15];
    bit done = 1'b0;

    always #4 clk = ~clk;

    assign rd_data = 8'h5A + 8'(rd_n);

    twi_mem_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
        .sel_strap_i(strap), .busy_i(busy), .rd_data_i(rd_data),
        .sel_stb_o(sel_stb), .rw_o(rw), .ahi_stb_o(ahi_stb), .alo_stb_o(alo_stb),
        .wd_stb_o(wd_stb), .byte_o(byte_w), .word_addr_o(waddr),
        .rd_req_o(rd_req), .stop_stb_o(stop_stb)
    );

    always @(negedge clk) begin
        if (sel_stb) sel_n++;
        if (ahi_stb) ahi_n++;
        if (alo_stb) alo_n++;
        if (wd_stb) begin
            wd_buf[wd_n[3:0]] = byte_w;
            wd_n++;
        end
        if (rd_req) rd_n++;
        if (stop_stb) stop_n++;
    end

    task automatic wc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] dev_byte(logic [1:0] s, logic p, logic r);
        return {4'b1010, s, p, r};
    endfunction

    task automatic bus_start();
        m_low = 1'b0; wc(Q);
        scl_m = 1'b1; wc(Q);
        m_low = 1'b1; wc(Q);
        scl_m = 1'b0; wc(Q);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; wc(Q);
        scl_m = 1'b1; wc(Q);
        m_low = 1'b0; wc(Q);
    endtask

    task automatic put_bit(logic b);
        m_low = !b; wc(Q);
        scl_m = 1'b1; wc(Q);
        scl_m = 1'b0; wc(Q);
    endtask

    task automatic get_bit(output logic b);
        logic first;
        m_low = 1'b0; wc(Q);
        scl_m = 1'b1; wc(2);
        first = sda_line;
        wc(Q / 2 - 2);
        b = sda_line;
        wc(Q / 2 - 1);
        if (sda_line != first) unstable++;
        wc(1);
        scl_m = 1'b0; wc(Q);
    endtask

    task automatic send_byte(logic [7:0] b, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        get_bit(a);
        ack = !a;
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic give_ack);
        logic x;
        for (int i = 7; i >= 0; i--) begin
            get_bit(x);
            b[i] = x;
        end
        put_bit(!give_ack);
        m_low = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 sda_oe after reset", int'(sda_oe), 0);
        chk("R1 word address after reset", int'(waddr), 0);
        chk("R1 strobes after reset", sel_n + ahi_n + alo_n + wd_n + rd_n, 0);
    endtask

    task automatic t_write();
        logic a;
        int s0 = sel_n, st0 = stop_n, w0 = wd_n, h0 = ahi_n, l0 = alo_n;
        bus_start();
        send_byte(dev_byte(strap, 1'b1, 1'b0), a);
        chk("R2 ack of matching device byte", int'(a), 1);
        chk("R2 sel_stb count", sel_n - s0, 1);
        chk("R2 rw_o for write", int'(rw), 0);
        send_byte(8'h3C, a); chk("R5 ack high address", int'(a), 1);
        send_byte(8'hF1, a); chk("R5 ack low address", int'(a), 1);
        send_byte(8'h11, a); chk("R5 ack data 0", int'(a), 1);
        send_byte(8'h22, a); chk("R5 ack data 1", int'(a), 1);
        send_byte(8'h33, a); chk("R5 ack data 2", int'(a), 1);
        bus_stop();
        wc(Q);
        chk("R5 word address with page bit", int'(waddr), 'h13CF1);
        chk("R5 data strobe count", wd_n - w0, 3);
        chk("R5 data byte 0", int'(wd_buf[w0]), 'h11);
        chk("R5 data byte 2", int'(wd_buf[w0 + 2]), 'h33);
        chk("R12 single high address strobe", ahi_n - h0, 1);
        chk("R12 single low address strobe", alo_n - l0, 1);
        chk("R9 stop strobe", stop_n - st0, 1);
        chk("R9 SDA released after stop", int'(sda_oe), 0);
    endtask

    task automatic t_mismatch();
        logic a;
        int s0 = sel_n, h0 = ahi_n;
        bus_start();
        send_byte(dev_byte(~strap, 1'b0, 1'b0), a);
        chk("R3 no ack on select mismatch", int'(a), 0);
        send_byte(8'h00, a);
        chk("R3 following byte ignored", int'(a), 0);
        bus_stop();
        bus_start();
        send_byte({4'b1011, strap, 2'b00}, a);
        chk("R3 no ack on tag mismatch", int'(a), 0);
        bus_stop();
        wc(Q);
        chk("R3 no strobes on mismatch", (sel_n - s0) + (ahi_n - h0), 0);
    endtask

    task automatic t_busy();
        logic a;
        int s0 = sel_n;
        busy = 1'b1;
        bus_start();
        send_byte(dev_byte(strap, 1'b0, 1'b0), a);
        chk("R4 no ack while busy", int'(a), 0);
        bus_stop();
        busy = 1'b0;
        bus_start();
        send_byte(dev_byte(strap, 1'b0, 1'b0), a);
        chk("R4 ack once not busy", int'(a), 1);
        bus_stop();
        chk("R4 sel_stb only when not busy", sel_n - s0, 1);
    endtask

    task automatic t_read();
        logic a;
        logic [7:0] b;
        int r0 = rd_n;
        unstable = 0;
        bus_start();
        send_byte(dev_byte(strap, 1'b0, 1'b1), a);
        chk("R2 ack of read device byte", int'(a), 1);
        chk("R2 rw_o for read", int'(rw), 1);
        recv_byte(b, 1'b1); chk("R6 read byte 0", int'(b), 'h5A);
        recv_byte(b, 1'b1); chk("R6 read byte 1", int'(b), 'h5B);
        recv_byte(b, 1'b0); chk("R6 read byte 2", int'(b), 'h5C);
        bus_stop();
        wc(Q);
        chk("R6 read loads stop after no-ack", rd_n - r0, 3);
        chk("R7 SDA stable while SCL high", unstable, 0);
    endtask

    task automatic t_abort();
        logic a;
        bus_start();
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
        bus_start();
        send_byte(dev_byte(strap, 1'b0, 1'b0), a);
        chk("R8 ack after mid-byte restart", int'(a), 1);
        send_byte(8'h01, a);
        send_byte(8'h02, a);
        bus_stop();
        chk("R8 address after restart", int'(waddr), 'h00102);
    endtask

    task automatic t_recover();
        logic a;
        bus_start();
        send_byte(dev_byte(strap, 1'b0, 1'b0), a);
        put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
        bus_start();
        for (int i = 0; i < 9; i++) put_bit(1'b1);
        bus_start();
        bus_stop();
        wc(Q);
        chk("R10 SDA released after recovery", int'(sda_oe), 0);
        bus_start();
        send_byte(dev_byte(strap, 1'b0, 1'b0), a);
        chk("R10 addressable after recovery", int'(a), 1);
        bus_stop();
    endtask

    task automatic t_glitch();
        logic a;
        int w0 = wd_n, st0 = stop_n;
        scl_m = 1'b1;
        wc(Q);
        glitch_low = 1'b1; wc(1); glitch_low = 1'b0;
        wc(Q);
        chk("R11 SDA pulse on idle bus gives no stop", stop_n - st0, 0);
        bus_start();
        send_byte(dev_byte(strap, 1'b0, 1'b0), a);
        send_byte(8'h55, a);
        scl_m = 1'b1; wc(1); scl_m = 1'b0;
        wc(Q);
        send_byte(8'hAA, a);
        chk("R11 ack after SCL pulse", int'(a), 1);
        send_byte(8'h77, a);
        bus_stop();
        chk("R11 address unaffected by SCL pulse", int'(waddr), 'h055AA);
        chk("R11 data unaffected by SCL pulse", int'(wd_buf[w0]), 'h77);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        wc(5);
        rst_n = 1'b1;
        wc(10);
        t_reset();
        t_write();
        t_mismatch();
        t_busy();
        t_read();
        t_abort();
        t_recover();
        t_glitch();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule